// File: doc/BRIEF.md
# Vector Rounding Shift-Right Narrowing Unit

This block is one datapath slice of a 128-bit SIMD execution pipe. It takes wide source elements and shifts each one right, either logically or arithmetically. Each result is rounded to nearest by adding back the last bit that the shift dropped. The block keeps only the low half of each rounded value, so every element becomes half as wide. Nothing saturates. A one-bit strobe captures a new operation, and the packed 128-bit result appears in a register one clock later.

There are two operand forms. In the register form, each element takes its own shift count from the matching wide element of a second vector. The narrowed results fill the low 64 bits and the upper 64 bits are zero. In the immediate form, one shift amount applies to every element. The old destination value is a second data source: results from the first source fill the low half, and results from the old destination fill the high half. All operands are sampled on the same edge, so a destination that also feeds the operation is handled safely.

A two-state controller tracks result validity. In ST_IDLE no fresh result is present. The transition IDLE_TO_HOLD happens on a strobe and captures a result. In ST_HOLD the result has just been captured. HOLD_TO_HOLD happens on another strobe and captures again. HOLD_TO_IDLE happens when there is no strobe, and the result register keeps its value.

Top module: `vrsn_unit`

## Requirements
- R1: While reset is active and after it is released, `res` is all zero and `res_valid` is 0 until the first strobe.
- R2: When `in_valid` is 1 at a rising edge, `res` takes the new result and `res_valid` is 1 in the following cycle. A cycle without a strobe drops `res_valid` to 0 and leaves `res` unchanged, whatever the other inputs do.
- R3: For a shift s, each element result is (x >> s) plus bit s-1 of x. With s = 0 there is no increment and x passes through.
- R4: With `arith` = 0, zeros shift in. With `arith` = 1, the element is treated as signed and copies of its sign bit shift in.
- R5: The narrowed result is the low half of the rounded value, with the add done at the full source width. A carry from the increment wraps into that low half and is not saturated. Example: 16-bit 0x01FF shifted by 1 gives byte 0x00.
- R6: In the register form (`imm_form` = 0), the shift for element i is the low log2(W) bits of element i of `src_b`, where W is the source element width. This equals that element modulo W.
- R7: In the register form, narrowed element i of `src_a` occupies bits [i*W/2 +: W/2] of `res`, and bits [127:64] are zero.
- R8: In the immediate form (`imm_form` = 1), the shift for every element is the low log2(W) bits of `imm`. Narrowed element i of `src_a` occupies bits [i*W/2 +: W/2]. Narrowed element i of `dst_old` occupies bits [64 + i*W/2 +: W/2].
- R9: `elem_sel` encodes W: 0 = 16 bits, 1 = 32 bits, 2 = 64 bits, 3 = 128 bits. Code 3 is defined only in the immediate form. In the register form it yields an all-zero result.
- R10: With `elem_sel` = 3, `imm_form` = 1 and `imm` = 0, `res[63:0]` equals `src_a[63:0]` and `res[127:64]` equals `dst_old[63:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture strobe |
| imm_form | input | 1 | 0 = register form, 1 = immediate form |
| arith | input | 1 | 0 = logical shift, 1 = arithmetic shift |
| elem_sel | input | 2 | Source element width code |
| src_a | input | 128 | First data source |
| src_b | input | 128 | Per-element shift vector (register form) |
| dst_old | input | 128 | Previous destination value (immediate form) |
| imm | input | 7 | Immediate shift amount |
| res | output | 128 | Registered packed result |
| res_valid | output | 1 | High in the cycle after a capture |

## Verification
If the controller were stuck in the wrong state, `res_valid` would disagree with the strobe of the previous cycle. A stray capture would change `res` during an idle cycle. Both faults are visible one cycle after the offending edge. A fault in the lane logic, such as a wrong shift source, a lost rounding bit, the wrong shift-in or a misplaced lane, corrupts specific result bytes in the same cycle the result appears. Sweeping every width code, both forms, both shift kinds and every immediate value exposes each of these faults at the result port.

// File: rtl/vrsn_pkg.sv
package vrsn_pkg;
    localparam int VEC_W = 128;

    typedef enum logic [1:0] {
        SZ_16  = 2'd0,
        SZ_32  = 2'd1,
        SZ_64  = 2'd2,
        SZ_128 = 2'd3
    } size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } state_e;
endpackage

// File: rtl/vrsn_rshr.sv
// One lane: rounding right shift of a W-bit value, keep the low W/2 bits.
module vrsn_rshr #(
    parameter int W  = 16,
    localparam int SW = $clog2(W),
    localparam int HW = W / 2
) (
    input  logic [W-1:0]  val,
    input  logic [SW-1:0] sh,
    input  logic          arith,
    output logic [HW-1:0] nar
);
    logic [W-1:0]  shifted;
    logic [W-1:0]  rounded;
    logic [SW-1:0] sh_m1;
    logic          rnd;
    logic [HW-1:0] unused_hi;

    always_comb begin
        sh_m1   = sh - SW'(1);
        shifted = arith ? W'($signed(val) >>> sh) : (val >> sh);
        rnd     = (sh == '0) ? 1'b0 : val[sh_m1];
        rounded = shifted + W'(rnd);
    end

    assign nar       = rounded[HW-1:0];
    assign unused_hi = rounded[W-1:HW];
endmodule

// File: rtl/vrsn_narrow.sv
// All lanes for one element width; produces the packed 128-bit candidate.
module vrsn_narrow #(
    parameter int VLEN = 128,
    parameter int W    = 16,
    parameter int IMMW = 7,
    localparam int N   = VLEN / W,
    localparam int SW  = $clog2(W),
    localparam int HW  = W / 2,
    localparam int HALF = VLEN / 2
) (
    input  logic [VLEN-1:0] src_a,
    input  logic [VLEN-1:0] src_b,
    input  logic [VLEN-1:0] dst_old,
    input  logic [IMMW-1:0] imm,
    input  logic            imm_form,
    input  logic            arith,
    output logic [VLEN-1:0] packed_out
);
    logic unused_bits;
    assign unused_bits = ^{src_b, imm};

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [SW-1:0] sh_lo;
        logic [HW-1:0] lo_nar;
        logic [HW-1:0] hi_nar;

        assign sh_lo = imm_form ? imm[SW-1:0] : src_b[i*W +: SW];

        vrsn_rshr #(.W(W)) u_lo (
            .val   (src_a[i*W +: W]),
            .sh    (sh_lo),
            .arith (arith),
            .nar   (lo_nar)
        );

        vrsn_rshr #(.W(W)) u_hi (
            .val   (dst_old[i*W +: W]),
            .sh    (imm[SW-1:0]),
            .arith (arith),
            .nar   (hi_nar)
        );

        assign packed_out[i*HW +: HW]        = lo_nar;
        assign packed_out[HALF + i*HW +: HW] = imm_form ? hi_nar : '0;
    end
endmodule

// File: rtl/vrsn_unit.sv
module vrsn_unit
    import vrsn_pkg::*;
#(
    parameter int VLEN = VEC_W,
    localparam int IMMW = $clog2(VLEN),
    localparam int NSZ  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            imm_form,
    input  logic            arith,
    input  logic [1:0]      elem_sel,
    input  logic [VLEN-1:0] src_a,
    input  logic [VLEN-1:0] src_b,
    input  logic [VLEN-1:0] dst_old,
    input  logic [IMMW-1:0] imm,
    output logic [VLEN-1:0] res,
    output logic            res_valid
);
    state_e          state_q;
    state_e          state_d;
    logic [VLEN-1:0] cand [NSZ];
    logic [VLEN-1:0] next_res;

    for (genvar g = 0; g < NSZ; g++) begin : g_size
        vrsn_narrow #(
            .VLEN (VLEN),
            .W    (16 << g),
            .IMMW (IMMW)
        ) u_nar (
            .src_a      (src_a),
            .src_b      (src_b),
            .dst_old    (dst_old),
            .imm        (imm),
            .imm_form   (imm_form),
            .arith      (arith),
            .packed_out (cand[g])
        );
    end

    always_comb begin
        unique case (size_e'(elem_sel))
            SZ_16:   next_res = cand[0];
            SZ_32:   next_res = cand[1];
            SZ_64:   next_res = cand[2];
            SZ_128:  next_res = imm_form ? cand[3] : '0;
            default: next_res = '0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = in_valid ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        res <= '0;
        else if (in_valid) res <= next_res;
    end

    assign res_valid = (state_q == ST_HOLD);
endmodule

// File: rtl/vrsn_unit_chk.sv
module vrsn_unit_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         imm_form,
    input logic [1:0]   elem_sel,
    input logic [127:0] src_a,
    input logic [127:0] dst_old,
    input logic [6:0]   imm,
    input logic [127:0] res,
    input logic         res_valid
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    assert_idle_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && $stable(res)));

    assert_reg_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !imm_form) |=> (res[127:64] == 64'd0));

    assert_reg_wide_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !imm_form && elem_sel == 2'd3) |=> (res == 128'd0));

    assert_zero_shift_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && imm_form && elem_sel == 2'd3 && imm == 7'd0) |=>
        (res[63:0] == $past(src_a[63:0]) && res[127:64] == $past(dst_old[63:0])));

    assert_byte_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && imm_form && elem_sel == 2'd0 && imm[3:0] == 4'd0) |=>
        (res[7:0] == $past(src_a[7:0])));
endmodule

bind vrsn_unit vrsn_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .imm_form  (imm_form),
    .elem_sel  (elem_sel),
    .src_a     (src_a),
    .dst_old   (dst_old),
    .imm       (imm),
    .res       (res),
    .res_valid (res_valid)
);

// File: tb/vrsn_unit_tb.sv
module vrsn_unit_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         imm_form = 1'b0;
    logic         arith = 1'b0;
    logic [1:0]   elem_sel = 2'd0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] dst_old = '0;
    logic [6:0]   imm = '0;
    logic [127:0] res;
    logic         res_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vrsn_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .imm_form(imm_form),
        .arith(arith), .elem_sel(elem_sel), .src_a(src_a), .src_b(src_b),
        .dst_old(dst_old), .imm(imm), .res(res), .res_valid(res_valid)
    );

    function automatic logic [63:0] ref_elem(input logic [127:0] v, input int w,
                                             input int s, input bit ar);
        logic [128:0] xe, sh, sum;
        logic r;
        for (int b = 0; b < 129; b++)
            xe[b] = (b < w) ? v[b] : (ar ? v[w-1] : 1'b0);
        sh  = ar ? 129'($signed(xe) >>> s) : (xe >> s);
        r   = (s > 0) ? xe[s-1] : 1'b0;
        sum = sh + {128'd0, r};
        ref_elem = '0;
        for (int b = 0; b < w/2; b++) ref_elem[b] = sum[b];
    endfunction

    function automatic logic [127:0] ref_res(input int sel, input bit fi, input bit ar,
            input logic [127:0] a, input logic [127:0] b, input logic [127:0] d,
            input int im);
        int w, n, hw, s;
        logic [127:0] t, r;
        logic [63:0] e;
        w = 16 << sel; n = 128 / w; hw = w / 2; r = '0;
        if (sel == 3 && !fi) return '0;
        for (int i = 0; i < n; i++) begin
            t = b >> (i*w);
            s = fi ? (im & (w-1)) : (int'(t[6:0]) & (w-1));
            e = ref_elem(a >> (i*w), w, s, ar);
            r = r | ({64'd0, e} << (i*hw));
            if (fi) begin
                e = ref_elem(d >> (i*w), w, im & (w-1), ar);
                r = r | ({64'd0, e} << (64 + i*hw));
            end
        end
        return r;
    endfunction

    task automatic check(input logic [127:0] got, input logic [127:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic issue(input int sel, input bit fi, input bit ar, input logic [127:0] a,
                         input logic [127:0] b, input logic [127:0] d, input int im);
        @(negedge clk);
        elem_sel = 2'(sel); imm_form = fi; arith = ar;
        src_a = a; src_b = b; dst_old = d; imm = 7'(im); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        logic [127:0] a, b, d, held;
        repeat (3) @(negedge clk);
        check(res, '0, "R1 reset res");
        check({127'd0, res_valid}, '0, "R1 reset valid");
        rst_n = 1'b1;
        @(negedge clk);
        check({127'd0, res_valid}, '0, "R1 after release");

        // R3 rounding: 0x0003 >> 1 = 1, +bit0 = 2; zero shift passes 0xAB
        issue(0, 1, 0, 128'h0003, '0, 128'h00AB, 1);
        check({120'd0, res[7:0]}, 128'h02, "R3 round up");
        check({127'd0, res_valid}, 128'd1, "R2 valid after strobe");
        issue(0, 1, 0, 128'h00AB, '0, '0, 0);
        check({120'd0, res[7:0]}, 128'hAB, "R3 zero shift");

        // R4: 0x8000 >> 9 arithmetic -> 0xC0, logical -> 0x40
        issue(0, 1, 1, 128'h8000, '0, '0, 9);
        check({120'd0, res[7:0]}, 128'hC0, "R4 arithmetic");
        issue(0, 1, 0, 128'h8000, '0, '0, 9);
        check({120'd0, res[7:0]}, 128'h40, "R4 logical");

        // R5: 0x01FF >> 1 + 1 = 0x100 -> byte 0x00
        issue(0, 0, 0, 128'h01FF, 128'h0001, '0, 0);
        check({120'd0, res[7:0]}, 128'h00, "R5 carry wraps");

        // R6: shift element 0xFFF1 modulo 16 = 1
        issue(0, 0, 0, 128'h0003, 128'hFFF1, '0, 0);
        check({120'd0, res[7:0]}, 128'h02, "R6 shift modulo");

        // R9: register form with 128-bit code is zero
        issue(3, 0, 1, rnd128(), rnd128(), rnd128(), 5);
        check(res, '0, "R9 reg form wide code");

        // R10
        a = rnd128(); d = rnd128();
        issue(3, 1, 1, a, '0, d, 0);
        check(res, {d[63:0], a[63:0]}, "R10 wide zero shift");

        // R2 hold: idle cycles with changing inputs leave res alone
        held = res;
        @(negedge clk);
        src_a = rnd128(); imm = 7'd3; elem_sel = 2'd1;
        @(negedge clk);
        check(res, held, "R2 hold res");
        check({127'd0, res_valid}, '0, "R2 valid drops");

        // Sweep: every size code, form, shift kind, every immediate value
        for (int sel = 0; sel < 4; sel++)
            for (int fi = 0; fi < 2; fi++)
                for (int ar = 0; ar < 2; ar++)
                    for (int im = 0; im < 128; im++) begin
                        a = rnd128(); b = rnd128(); d = rnd128();
                        issue(sel, fi[0], ar[0], a, b, d, im);
                        check(res, ref_res(sel, fi[0], ar[0], a, b, d, im),
                              fi ? "R8 imm form sweep" : "R7 reg form sweep");
                    end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule